// File: doc/BRIEF.md
# Tagged Multi-Source Result Queue

This block gathers conversion results from up to seven converter channels into one shared first-in first-out queue. Each channel raises a one-cycle valid strobe with its data word and a signed-format flag. If the queue is switched on and that channel's own enable is set, the block keeps the result. Every stored entry records the data, the 3-bit index of the channel that produced it, and the signed-format flag.

Each channel has a one-entry holding register. Results from several channels in the same cycle are moved into the queue one per cycle, lowest channel index first. The read side is first-word-fall-through: the oldest entry is always visible on the read outputs, and a pop strobe removes it.

Status outputs report the number of entries held, a ready flag, an interrupt gated by an enable input, and a sticky overrun error. The error is raised when a result cannot be stored, and software clears it. Turning the queue off empties it.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset, fill_count is 0, ready is 0, irq is 0 and ovr_err is 0.
- R2: A result strobed while fifo_en and its channel bit in src_en are high is visible on the read outputs after the second rising clock edge. The entry shows rd_data equal to the input data, rd_src equal to the channel index (0 to 6, as a 3-bit binary number) and rd_sign equal to the input sign flag.
- R3: A result strobed while its channel bit in src_en is low, or while fifo_en is low, is not stored, and fill_count does not change.
- R4: Results strobed by several enabled channels in the same cycle are stored in ascending channel index, one per clock cycle.
- R5: Entries are read oldest first. A pop while ready is high removes the head entry and decrements fill_count.
- R6: fill_count equals the number of entries held. A store and a pop in the same cycle leave it unchanged.
- R7: ready is high exactly when fill_count is nonzero. irq equals ready AND irq_en.
- R8: A result that arrives for a channel whose holding register still holds an entry not moved to the queue in that cycle is dropped, and ovr_err is set.
- R9: With fill_count equal to DEPTH at the start of a cycle, the entry moved in that cycle is dropped, ovr_err is set, and the stored entries are unchanged.
- R10: While fifo_en is low, the queue and all holding registers are emptied and fill_count reads 0. ovr_err keeps its value.
- R11: ovr_err stays set until a cycle with ovr_clr high. If a new overrun occurs in that same cycle, setting wins.
- R12: A pop while the queue is empty has no effect: fill_count stays 0, and later entries are read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Global enable; low flushes the queue |
| src_en | input | NUM_SRC | Per-channel store enable |
| res_valid | input | NUM_SRC | Per-channel result strobe |
| res_data | input | NUM_SRC*DATA_W | Result words, channel i at bits [i*DATA_W +: DATA_W] |
| res_signed | input | NUM_SRC | Per-channel signed-format flag |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | DATA_W | Head entry data |
| rd_src | output | 3 | Head entry channel index |
| rd_sign | output | 1 | Head entry signed-format flag |
| fill_count | output | CNT_W | Entries currently held |
| ready | output | 1 | Queue not empty |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Ready interrupt |
| ovr_clr | input | 1 | Clear the overrun error |
| ovr_err | output | 1 | Sticky overrun error |

## Verification
The bench sweeps every nonzero combination of the seven result strobes with all channels enabled. For each combination it checks the fill count against the population count of the pattern and pops the entries to confirm ascending-index order and per-entry data, tag and sign. This separates a correct priority order from a reversed or lost one.

A channel-enable mask with alternating bits shows that only enabled channels are stored. A back-to-back strobe on one channel that is still held provokes the per-channel overrun. A seventeen-result stream into a sixteen-deep queue provokes the full-queue drop. Single-entry cases measure the two-edge latency, a pop in the same cycle as a store, a pop on an empty queue, the flush, and the clearing of the error.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  localparam int ID_W = 3;
  typedef logic [ID_W-1:0] src_id_t;

  // next occupancy after one cycle of store/remove
  function automatic logic [15:0] occ_next(input logic [15:0] cur, input logic wr, input logic rd);
    logic [15:0] r;
    r = cur;
    if (wr && !rd) r = cur + 16'd1;
    else if (rd && !wr) r = cur - 16'd1;
    return r;
  endfunction
endpackage

// File: rtl/rfifo_hold.sv
module rfifo_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sign,
  input  logic              drain,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sign,
  output logic              collide
);
  assign collide = accept & out_valid & ~drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sign  <= 1'b0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (accept && !collide) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_sign  <= in_sign;
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !flush) |=> (out_valid && $stable(out_data)));
  // R4
  drain_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> out_valid);
endmodule

// File: rtl/rfifo_arb.sv
module rfifo_arb #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any,
  output logic [2:0]   idx
);
  function automatic logic [N-1:0] lowest_bit(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [2:0] bit_index(input logic [N-1:0] oh);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (oh[i]) r = 3'(i);
    return r;
  endfunction

  assign grant = lowest_bit(req);
  assign any   = |req;
  assign idx   = bit_index(grant);

  // R4
  grant_oh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));
  // R4
  grant_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0));
endmodule

// File: rtl/rfifo_store.sv
module rfifo_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [2:0]        push_id,
  input  logic              push_sign,
  input  logic              pop_req,
  output logic [DATA_W-1:0] head_data,
  output logic [2:0]        head_id,
  output logic              head_sign,
  output logic [CNT_W-1:0]  count,
  output logic              drop_evt
);
  import rfifo_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = DATA_W + ID_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic full, empty, wr, rd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign wr       = push & ~full;
  assign rd       = pop_req & ~empty;
  assign drop_evt = push & full;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= {push_sign, push_id, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr) wp <= bump(wp);
      if (rd) rp <= bump(rp);
      count <= CNT_W'(occ_next(16'(count), wr, rd));
    end
  end

  assign {head_sign, head_id, head_data} = mem[rp];

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !pop_req && !flush) |=> (count == CNT_W'(DEPTH)));
  // R12
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !push) |=> (count == '0));
  // R6
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_req && !full && !empty && !flush) |=> $stable(count));
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int CNT_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fifo_en,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        res_valid,
  input  logic [NUM_SRC*DATA_W-1:0] res_data,
  input  logic [NUM_SRC-1:0]        res_signed,
  input  logic                      rd_pop,
  output logic [DATA_W-1:0]         rd_data,
  output logic [2:0]                rd_src,
  output logic                      rd_sign,
  output logic [CNT_W-1:0]          fill_count,
  output logic                      ready,
  input  logic                      irq_en,
  output logic                      irq,
  input  logic                      ovr_clr,
  output logic                      ovr_err
);
  logic                 flush;
  logic [NUM_SRC-1:0]   accept, held, grant, collide;
  logic [DATA_W-1:0]    held_data [NUM_SRC];
  logic [NUM_SRC-1:0]   held_sign;
  logic                 gnt_any, drop_evt, ovr_evt;
  logic [2:0]           gnt_idx;
  logic [DATA_W-1:0]    sel_data;
  logic                 sel_sign;

  assign flush  = ~fifo_en;
  assign accept = res_valid & src_en & {NUM_SRC{fifo_en}};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_hold
    rfifo_hold #(.DATA_W(DATA_W)) hold_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .accept(accept[g]),
      .in_data(res_data[g*DATA_W +: DATA_W]), .in_sign(res_signed[g]),
      .drain(grant[g]), .out_valid(held[g]), .out_data(held_data[g]),
      .out_sign(held_sign[g]), .collide(collide[g]));
  end

  rfifo_arb #(.N(NUM_SRC)) arb_i (
    .clk(clk), .rst_n(rst_n), .req(held & {NUM_SRC{fifo_en}}),
    .grant(grant), .any(gnt_any), .idx(gnt_idx));

  always_comb begin
    sel_data = '0;
    sel_sign = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) begin
        sel_data = held_data[i];
        sel_sign = held_sign[i];
      end
    end
  end

  rfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(gnt_any),
    .push_data(sel_data), .push_id(gnt_idx), .push_sign(sel_sign),
    .pop_req(rd_pop), .head_data(rd_data), .head_id(rd_src),
    .head_sign(rd_sign), .count(fill_count), .drop_evt(drop_evt));

  assign ovr_evt = (|collide) | drop_evt;
  assign ready   = (fill_count != '0);
  assign irq     = ready & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_err <= 1'b0;
    else if (ovr_evt) ovr_err <= 1'b1;
    else if (ovr_clr) ovr_err <= 1'b0;
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ready && irq_en));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (fill_count == '0));
  // R11
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !ovr_clr) |=> ovr_err);
  // R11
  ovr_set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_err);
endmodule

// File: tb/adc_result_fifo_tb.sv
module adc_result_fifo_tb_top;
  localparam int NS = 7;
  localparam int DW = 16;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic [NS-1:0] src_en = '1;
  logic [NS-1:0] res_valid = '0;
  logic [NS*DW-1:0] res_data = '0;
  logic [NS-1:0] res_signed = '0;
  logic rd_pop = 1'b0;
  logic irq_en = 1'b0;
  logic ovr_clr = 1'b0;
  logic [DW-1:0] rd_data;
  logic [2:0] rd_src;
  logic rd_sign, ready, irq, ovr_err;
  logic [7:0] fill_count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_result_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .src_en(src_en),
    .res_valid(res_valid), .res_data(res_data), .res_signed(res_signed),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_src(rd_src), .rd_sign(rd_sign),
    .fill_count(fill_count), .ready(ready), .irq_en(irq_en), .irq(irq),
    .ovr_clr(ovr_clr), .ovr_err(ovr_err));

  function automatic logic [15:0] exp_data(input int s, input int k);
    return 16'((k * 37 + s * 4099) & 16'hFFFF);
  endfunction
  function automatic logic exp_sign(input int s, input int k);
    return ((s + k) % 2) == 1;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [NS-1:0] m, input int k);
    res_valid = m;
    for (int s = 0; s < NS; s++) begin
      res_data[s*DW +: DW] = exp_data(s, k);
      res_signed[s] = exp_sign(s, k);
    end
  endtask

  task automatic present(input logic [NS-1:0] m, input int k);
    load(m, k);
    tick();
    res_valid = '0;
  endtask

  task automatic pop_expect(input int s, input int k, input string req);
    chk(rd_data == exp_data(s, k), req, rd_data, exp_data(s, k));
    chk(rd_src == 3'(s), req, rd_src, s);
    chk(rd_sign == exp_sign(s, k), req, rd_sign, exp_sign(s, k));
    rd_pop = 1'b1;
    tick();
    rd_pop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(fill_count == 0, "R1", fill_count, 0);
    chk(ready == 0 && irq == 0, "R1", ready, 0);
    chk(ovr_err == 0, "R1", ovr_err, 0);
    rst_n = 1'b1;
    fifo_en = 1'b1;
    tick();

    // R2 latency and tagging
    present(7'b0001000, 200);
    chk(fill_count == 0, "R2", fill_count, 0);
    tick();
    chk(fill_count == 1 && ready, "R2", fill_count, 1);
    chk(irq == 0, "R7", irq, 0);
    irq_en = 1'b1;
    #1;
    chk(irq == 1, "R7", irq, 1);
    pop_expect(3, 200, "R2");
    chk(ready == 0 && irq == 0, "R7", ready, 0);

    // R4 R5 R6 sweep over all strobe patterns
    for (int m = 1; m < (1 << NS); m++) begin
      present(7'(m), m);
      repeat (8) tick();
      chk(fill_count == 8'($countones(7'(m))), "R6", fill_count, $countones(7'(m)));
      for (int s = 0; s < NS; s++) if (m[s]) pop_expect(s, m, "R4");
      chk(fill_count == 0, "R5", fill_count, 0);
    end

    // R3 per-channel enable and global enable filtering
    src_en = 7'b0101010;
    present('1, 300);
    repeat (8) tick();
    chk(fill_count == 3, "R3", fill_count, 3);
    pop_expect(1, 300, "R3");
    pop_expect(3, 300, "R3");
    pop_expect(5, 300, "R3");
    src_en = '1;
    fifo_en = 1'b0;
    present('1, 301);
    fifo_en = 1'b1;
    repeat (4) tick();
    chk(fill_count == 0, "R3", fill_count, 0);

    // R6 store and pop in the same cycle
    present(7'b0010000, 9);
    repeat (3) tick();
    present(7'b0000100, 10);
    chk(rd_src == 3'd4, "R6", rd_src, 4);
    rd_pop = 1'b1;
    tick();
    rd_pop = 1'b0;
    chk(fill_count == 1, "R6", fill_count, 1);
    pop_expect(2, 10, "R6");

    // R12 pop on empty
    rd_pop = 1'b1;
    tick();
    rd_pop = 1'b0;
    chk(fill_count == 0 && !ready, "R12", fill_count, 0);
    present(7'b0100000, 77);
    tick();
    pop_expect(5, 77, "R12");

    // R8 holding register collision
    chk(ovr_err == 0, "R8", ovr_err, 0);
    load(7'b0000011, 1);
    tick();
    load(7'b0000010, 2);
    tick();
    res_valid = '0;
    repeat (4) tick();
    chk(ovr_err == 1, "R8", ovr_err, 1);
    chk(fill_count == 2, "R8", fill_count, 2);
    pop_expect(0, 1, "R8");
    pop_expect(1, 1, "R8");

    // R10 flush keeps the error
    present('1, 400);
    repeat (2) tick();
    fifo_en = 1'b0;
    tick();
    chk(fill_count == 0 && !ready, "R10", fill_count, 0);
    chk(ovr_err == 1, "R10", ovr_err, 1);
    fifo_en = 1'b1;
    repeat (8) tick();
    chk(fill_count == 0, "R10", fill_count, 0);

    // R11 clear
    ovr_clr = 1'b1;
    tick();
    ovr_clr = 1'b0;
    chk(ovr_err == 0, "R11", ovr_err, 0);

    // R9 full queue drop
    for (int k = 0; k <= DP; k++) begin
      load(7'b0000001, 500 + k);
      tick();
    end
    res_valid = '0;
    repeat (4) tick();
    chk(fill_count == 8'(DP), "R9", fill_count, DP);
    chk(ovr_err == 1, "R9", ovr_err, 1);
    for (int k = 0; k < DP; k++) pop_expect(0, 500 + k, "R9");
    chk(fill_count == 0, "R9", fill_count, 0);
    ovr_clr = 1'b1;
    tick();
    ovr_clr = 1'b0;
    chk(ovr_err == 0, "R11", ovr_err, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule